// File: doc/BRIEF.md
# Push-Button Filter-Setting Cycler

This block turns presses of one front-panel button into a 3-bit loop-bandwidth setting for a converter's clock-recovery filter. Each clean press moves the setting up by one, and after the top value it goes back to the bottom value. The setting runs from 1 to 7, so zero is never used. For every new value the block frames a control byte. It then asks an external bus master to write that byte to control register 11, using a request/acknowledge pair.

Three indicator outputs show the setting as a plain binary code. A one-cycle persist strobe carries each new value that a press produces, so an external nonvolatile store can save it. At power-up, that store can restore the last setting through a load input. The block also issues a write for a restored setting. It issues no write until the bus master reports that it is ready.

Top module: `filt_cycler`

## Requirements
- R1: After reset the setting is 1, the indicators read 001, and no write request or persist strobe is asserted.
- R2: Each accepted press raises the setting by exactly one.
- R3: A press at setting 7 returns the setting to 1. The setting is never 0.
- R4: The write targets address 11. Its data byte has bit 7 = 1, bit 0 = 1, bits 6:5 = 0 and bit 1 = 0, with the setting in bits 4:2. This gives 0x85 for setting 1, 0x89 for setting 2 and 0x9D for setting 7.
- R5: The indicator outputs equal the setting, with bit 0 on indicator 0.
- R6: Each accepted press gives exactly one single-cycle persist strobe, and the persist value equals the new setting.
- R7: A button level held for fewer than the debounce interval has no effect. A press held for a long time acts once, on the press and not on the release.
- R8: A press that arrives while a write is pending (requested but not yet acknowledged) is ignored. It changes no setting and gives no strobe.
- R9: A load pulse sets the setting to the load value, and a load value of 0 becomes 1. A load issues a write but gives no persist strobe. A load that arrives while a write is pending is ignored.
- R10: No write request rises while ready is low. Once raised, the request and its data stay constant until the cycle in which it is acknowledged, and the request is low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| btn_i | input | 1 | Raw button level, active high, asynchronous |
| load_i | input | 1 | One-cycle pulse that restores the setting |
| load_val_i | input | 3 | Setting to restore |
| ready_i | input | 1 | Bus master is ready to take writes |
| wr_ack_i | input | 1 | Bus master has completed the current write |
| wr_req_o | output | 1 | Write request, held until acknowledged |
| wr_addr_o | output | 8 | Target register address (11) |
| wr_data_o | output | 8 | Framed control byte |
| persist_o | output | 1 | One-cycle strobe to save a new value |
| persist_val_o | output | 3 | Value to save |
| led_o | output | 3 | Indicator outputs, binary setting |

## Verification
A press reaches the block as a raw level. It passes through two synchronizer flops and a debounce count before it is accepted. The setting, the indicators and the persist strobe all update on the same edge, and the request rises one edge after that if ready is high. For this reason the bench holds each press for well over that latency, gathers persist strobes with a negedge monitor, and checks the indicators only after the press has been released. Loads and acknowledges are driven on a negedge, take effect at the next posedge, and are checked on the negedge that follows. The wait for a request is polled with a bound, and the bench then checks that the request and data stay steady for several cycles before it acknowledges.

// File: rtl/filt_cycler_pkg.sv
package filt_cycler_pkg;
  localparam int SET_W  = 3;
  localparam int BYTE_W = 8;
  localparam int SET_LO = 2;            // setting field base bit in register byte
  localparam logic [SET_W-1:0] SET_MIN = SET_W'(1);
  localparam logic [SET_W-1:0] SET_MAX = SET_W'(7);

  typedef logic [SET_W-1:0] setting_t;

  function automatic setting_t next_setting(setting_t s);
    return (s == SET_MAX) ? SET_MIN : s + SET_W'(1);
  endfunction

  function automatic setting_t clamp_load(setting_t s);
    return (s == '0) ? SET_MIN : s;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_byte(setting_t s);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[BYTE_W-1] = 1'b1;
    b[0] = 1'b1;
    b[SET_LO +: SET_W] = s;
    return b;
  endfunction
endpackage

// File: rtl/fc_debounce.sv
module fc_debounce #(
  parameter int DB_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic rise_o
);
  localparam int CW = $clog2(DB_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(DB_CYC - 1);

  logic [1:0]    sync_q;
  logic          stable_q;
  logic [CW-1:0] cnt_q;
  logic          rise_q;
  logic          differ;
  logic          expire;

  assign differ = sync_q[1] != stable_q;
  assign expire = differ && (cnt_q == LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= '0;
      stable_q <= 1'b0;
      cnt_q    <= '0;
      rise_q   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], btn_i};
      rise_q <= expire && sync_q[1];
      if (!differ) begin
        cnt_q <= '0;
      end else if (expire) begin
        stable_q <= sync_q[1];
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign rise_o = rise_q;

  // R7: a press pulse lasts one cycle and only follows a high filtered level
  assert_rise_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  assert_rise_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> stable_q);
endmodule

// File: rtl/fc_setting.sv
module fc_setting
  import filt_cycler_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     press_i,
  input  logic     load_i,
  input  setting_t load_val_i,
  input  logic     done_i,
  output setting_t setting_o,
  output logic     pend_o,
  output logic     persist_o,
  output setting_t persist_val_o
);
  setting_t set_q, pval_q;
  logic     pend_q, pst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q  <= SET_MIN;
      pend_q <= 1'b0;
      pst_q  <= 1'b0;
      pval_q <= SET_MIN;
    end else begin
      pst_q <= 1'b0;
      if (pend_q) begin
        if (done_i) pend_q <= 1'b0;
      end else if (load_i) begin
        set_q  <= clamp_load(load_val_i);
        pend_q <= 1'b1;
      end else if (press_i) begin
        set_q  <= next_setting(set_q);
        pval_q <= next_setting(set_q);
        pend_q <= 1'b1;
        pst_q  <= 1'b1;
      end
    end
  end

  assign setting_o     = set_q;
  assign pend_o        = pend_q;
  assign persist_o     = pst_q;
  assign persist_val_o = pval_q;

  assert_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setting_o != '0);
  assert_persist_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    persist_o |-> (persist_val_o == setting_o) && pend_o);
  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && !done_i |=> pend_o && $stable(setting_o) && !persist_o);
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_i && !pend_o && !load_i |=>
      (setting_o == (($past(setting_o) == SET_MAX) ? SET_MIN : $past(setting_o) + SET_W'(1))));
endmodule

// File: rtl/fc_wr_if.sv
module fc_wr_if
  import filt_cycler_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int REG_ADDR = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_i,
  input  logic              ready_i,
  input  logic              ack_i,
  input  setting_t          setting_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              done_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
    end else if (req_q) begin
      if (ack_i) req_q <= 1'b0;
    end else if (pend_i && ready_i) begin
      req_q <= 1'b1;
    end
  end

  assign req_o  = req_q;
  assign done_o = req_q && ack_i;
  assign addr_o = ADDR_W'(REG_ADDR);
  assign data_o = pack_byte(setting_i);

  assert_req_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(ready_i));
  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(data_o));
  assert_req_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> !req_o);
  assert_framing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> data_o[BYTE_W-1] && data_o[0] && !data_o[1] && data_o[SET_LO +: SET_W] != '0);
endmodule

// File: rtl/filt_cycler.sv
module filt_cycler
  import filt_cycler_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int DEBOUNCE_MS = 20,
  parameter int ADDR_W      = 8,
  parameter int REG_ADDR    = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              btn_i,
  input  logic              load_i,
  input  logic [2:0]        load_val_i,
  input  logic              ready_i,
  input  logic              wr_ack_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              persist_o,
  output logic [2:0]        persist_val_o,
  output logic [2:0]        led_o
);
  localparam int DB_RAW = (CLK_HZ / 1000) * DEBOUNCE_MS;
  localparam int DB_CYC = (DB_RAW < 2) ? 2 : DB_RAW;

  logic     press;
  logic     pend;
  logic     done;
  setting_t setting;

  fc_debounce #(.DB_CYC(DB_CYC)) u_db (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .btn_i (btn_i),
    .rise_o(press)
  );

  fc_setting u_set (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .press_i      (press),
    .load_i       (load_i),
    .load_val_i   (load_val_i),
    .done_i       (done),
    .setting_o    (setting),
    .pend_o       (pend),
    .persist_o    (persist_o),
    .persist_val_o(persist_val_o)
  );

  fc_wr_if #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_i   (pend),
    .ready_i  (ready_i),
    .ack_i    (wr_ack_i),
    .setting_i(setting),
    .req_o    (wr_req_o),
    .addr_o   (wr_addr_o),
    .data_o   (wr_data_o),
    .done_o   (done)
  );

  assign led_o = setting;

  assert_led_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> wr_data_o[4:2] == led_o);
endmodule

// File: tb/filt_cycler_tb.sv
`timescale 1ns/1ps
module filt_cycler_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       btn = 1'b0, load = 1'b0, ready = 1'b1, ack = 1'b0;
  logic [2:0] load_val = 3'd0;
  logic       req, persist;
  logic [7:0] addr, data;
  logic [2:0] pval, led;

  int errors = 0, checks = 0;
  int pcnt = 0;
  logic [2:0] plast = 3'd0;
  logic [2:0] exp_set;

  always #2 clk = ~clk;

  filt_cycler #(.CLK_HZ(4000), .DEBOUNCE_MS(1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .btn_i(btn), .load_i(load), .load_val_i(load_val),
    .ready_i(ready), .wr_ack_i(ack), .wr_req_o(req), .wr_addr_o(addr), .wr_data_o(data),
    .persist_o(persist), .persist_val_o(pval), .led_o(led));

  always @(negedge clk) if (rst_n && persist) begin pcnt++; plast = pval; end

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] frame(input logic [2:0] s);
    return 8'h81 + {3'b000, s, 2'b00};
  endfunction

  task automatic press(input int hold);
    @(negedge clk) btn = 1'b1;
    repeat (hold) @(negedge clk);
    btn = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic serve(input logic [7:0] expd, input string tag);
    int n = 0;
    while (!req && n < 60) begin @(negedge clk); n++; end
    chk(req, {tag, " request raised"}, req, 1);
    chk(addr == 8'd11, "R4 address", addr, 11);
    chk(data == expd, {tag, " data byte"}, data, expd);
    repeat (3) begin
      @(negedge clk);
      chk(req && data == expd, "R10 request held until ack", {req, data}, {1'b1, expd});
    end
    ack = 1'b1;
    @(negedge clk) ack = 1'b0;
    chk(!req, "R10 request low after ack", req, 0);
  endtask

  initial begin
    int p0;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(led == 3'd1, "R1 reset setting", led, 1);
    chk(!req && !persist, "R1 idle outputs", {req, persist}, 0);

    // R2 R3 R4 R5 R6: sweep two full cycles
    exp_set = 3'd1;
    for (int i = 0; i < 14; i++) begin
      exp_set = (exp_set == 3'd7) ? 3'd1 : exp_set + 3'd1;
      p0 = pcnt;
      press(20);
      chk(pcnt == p0 + 1, "R6 one persist strobe", pcnt - p0, 1);
      chk(plast == exp_set, "R6 persist value", plast, exp_set);
      chk(led == exp_set, "R2 R3 R5 indicators", led, exp_set);
      serve(frame(exp_set), "R4");
    end

    // R7: short glitch ignored, long hold acts once
    p0 = pcnt;
    @(negedge clk) btn = 1'b1;
    repeat (2) @(negedge clk);
    btn = 1'b0;
    repeat (30) @(negedge clk);
    chk(led == exp_set && pcnt == p0 && !req, "R7 glitch ignored", led, exp_set);
    exp_set = (exp_set == 3'd7) ? 3'd1 : exp_set + 3'd1;
    press(200);
    chk(pcnt == p0 + 1 && led == exp_set, "R7 long hold acts once", pcnt - p0, 1);
    serve(frame(exp_set), "R7");

    // R8: press while pending ignored
    p0 = pcnt;
    exp_set = (exp_set == 3'd7) ? 3'd1 : exp_set + 3'd1;
    press(20);
    press(20);
    chk(led == exp_set, "R8 second press ignored", led, exp_set);
    chk(pcnt == p0 + 1, "R8 no extra strobe", pcnt - p0, 1);
    serve(frame(exp_set), "R8");

    // R10: no request while ready low
    ready = 1'b0;
    exp_set = (exp_set == 3'd7) ? 3'd1 : exp_set + 3'd1;
    bad = 0;
    @(negedge clk) btn = 1'b1;
    repeat (20) begin @(negedge clk); if (req) bad++; end
    btn = 1'b0;
    repeat (20) begin @(negedge clk); if (req) bad++; end
    chk(bad == 0, "R10 request gated by ready", bad, 0);
    ready = 1'b1;
    serve(frame(exp_set), "R10");

    // R9: load forcing, write, no persist
    p0 = pcnt;
    @(negedge clk) begin load = 1'b1; load_val = 3'd0; end
    @(negedge clk) load = 1'b0;
    chk(led == 3'd1, "R9 load zero forced to one", led, 1);
    serve(frame(3'd1), "R9");
    @(negedge clk) begin load = 1'b1; load_val = 3'd5; end
    @(negedge clk) load = 1'b0;
    chk(led == 3'd5, "R9 load value", led, 5);
    serve(8'h95, "R9");
    chk(pcnt == p0, "R9 load gives no strobe", pcnt - p0, 0);
    press(20);
    @(negedge clk) begin load = 1'b1; load_val = 3'd3; end
    @(negedge clk) load = 1'b0;
    chk(led == 3'd6, "R9 load ignored while pending", led, 6);
    serve(frame(3'd6), "R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule